// File: doc/BRIEF.md
# Framed Three-Bit Pattern Detector

This block watches a serial bit stream, one bit per clock, and cuts it into consecutive three-bit frames that never share a bit. The first bit taken after reset opens the first frame, and every third bit after that closes a frame. The output `hit` goes high during the closing bit of a frame only when that frame reads 010 or 110, with the leftmost bit received first. Because both accepted patterns have the same last two bits, the opening bit of a frame never affects the result. The machine can therefore be reduced to four states, which fit in two state bits.

The output is a Mealy function of the present state and the live input bit. A match is reported in the same cycle as the closing bit, and no register sits on the output path. The binary code of each state is a parameter, as is the width of the state register. This lets a dense two-bit assignment, a one-hot assignment or any other distinct assignment be tried without changing the function. Any state code that matches none of the four parameters falls back to the frame-start state on the next edge.

Top module: `seq_frame_det`

## Requirements
- R1: While `rst` is high at a rising edge, the machine enters the frame-start state. The first bit sampled after `rst` falls is the opening bit of a new frame, and `hit` is 0 during every cycle in which the machine sits in the frame-start state.
- R2: During the closing (third) bit of a frame, `hit` is 1 exactly when the middle bit of that frame was 1 and the current closing bit is 0. Otherwise `hit` is 0.
- R3: The value of the opening bit of a frame has no effect on `hit`. Frames 010 and 110 both give 1, and frames 000, 100, 011 and 111 all give 0.
- R4: Frames do not overlap. After every closing bit the machine returns to frame start, whatever the input. A 010 or 110 pattern that straddles a frame boundary produces no `hit`.
- R5: `hit` is 0 during the opening and middle bits of every frame.
- R6: `hit` reflects the current `din` in the same clock cycle, with no register delay between the closing bit and the result.
- R7: Any set of distinct state codes supplied through the code parameters, including a wider one-hot set, gives the same `hit` sequence for the same input stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one stream bit per cycle |
| rst | input | 1 | Synchronous active-high reset to frame start |
| din | input | 1 | Serial stream bit |
| hit | output | 1 | Mealy match flag, high on the closing bit of a 010 or 110 frame |

## Verification
A result is due in the cycle that carries its bit. The bench drives `din` on the falling edge and reads `hit` 5 ns later, before the next rising edge moves the state. A reset takes effect one rising edge after `rst` is driven, so the reference model clears its frame position only after that edge has been modelled. The bit in flight during the reset cycle is judged against the pre-reset frame position. Every expected value is pushed into a queue in the cycle the bit is driven and popped by the monitor in that same cycle.

// File: rtl/seq_frame_pkg.sv
package seq_frame_pkg;

  // Roles of the present state that the next-state and output logic need.
  typedef struct packed {
    logic start;   // frame start: next bit opens a frame
    logic head;    // opening bit consumed, its value discarded
    logic high;    // middle bit was 1
  } role_t;

  // One-hot description of the state to enter on the next edge.
  typedef struct packed {
    logic start;
    logic head;
    logic low;
    logic high;
  } next_t;

endpackage

// File: rtl/seq_frame_decode.sv
module seq_frame_decode #(
  parameter int                 STATE_W    = 2,
  parameter logic [STATE_W-1:0] CODE_START = 2'd0,
  parameter logic [STATE_W-1:0] CODE_HEAD  = 2'd1,
  parameter logic [STATE_W-1:0] CODE_HIGH  = 2'd3
) (
  input  logic [STATE_W-1:0]   code,
  output seq_frame_pkg::role_t role
);

  always_comb begin
    role.start = (code == CODE_START);
    role.head  = (code == CODE_HEAD);
    role.high  = (code == CODE_HIGH);
  end

endmodule

// File: rtl/seq_frame_next.sv
module seq_frame_next (
  input  logic                 in_start,
  input  logic                 in_head,
  input  logic                 din,
  output seq_frame_pkg::next_t nxt
);

  // Start -> head on any bit; head splits on the middle bit;
  // both middle states and any unknown code go back to start.
  always_comb begin
    nxt.head  = in_start;
    nxt.high  = in_head & din;
    nxt.low   = in_head & ~din;
    nxt.start = ~(in_start | in_head);
  end

endmodule

// File: rtl/seq_frame_encode.sv
module seq_frame_encode #(
  parameter int                 STATE_W    = 2,
  parameter logic [STATE_W-1:0] CODE_START = 2'd0,
  parameter logic [STATE_W-1:0] CODE_HEAD  = 2'd1,
  parameter logic [STATE_W-1:0] CODE_LOW   = 2'd2,
  parameter logic [STATE_W-1:0] CODE_HIGH  = 2'd3
) (
  input  seq_frame_pkg::next_t nxt,
  output logic [STATE_W-1:0]   code
);

  // The next-state vector is one-hot, so an AND-OR mux selects the code.
  always_comb begin
    code = ({STATE_W{nxt.start}} & CODE_START)
         | ({STATE_W{nxt.head}}  & CODE_HEAD)
         | ({STATE_W{nxt.low}}   & CODE_LOW)
         | ({STATE_W{nxt.high}}  & CODE_HIGH);
  end

endmodule

// File: rtl/seq_frame_out.sv
module seq_frame_out (
  input  logic in_high,
  input  logic din,
  output logic hit
);

  // Closing bit 0 after a middle bit of 1 completes 010 or 110.
  always_comb hit = in_high & ~din;

endmodule

// File: rtl/seq_frame_det.sv
module seq_frame_det #(
  parameter int                 STATE_W    = 2,
  parameter logic [STATE_W-1:0] CODE_START = 2'd0,
  parameter logic [STATE_W-1:0] CODE_HEAD  = 2'd1,
  parameter logic [STATE_W-1:0] CODE_LOW   = 2'd2,
  parameter logic [STATE_W-1:0] CODE_HIGH  = 2'd3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);

  logic [STATE_W-1:0]   st_q;
  logic [STATE_W-1:0]   st_d;
  seq_frame_pkg::role_t role;
  seq_frame_pkg::next_t nxt;

  seq_frame_decode #(
    .STATE_W(STATE_W), .CODE_START(CODE_START),
    .CODE_HEAD(CODE_HEAD), .CODE_HIGH(CODE_HIGH)
  ) u_decode (
    .code(st_q),
    .role(role)
  );

  seq_frame_next u_next (
    .in_start(role.start),
    .in_head (role.head),
    .din     (din),
    .nxt     (nxt)
  );

  seq_frame_encode #(
    .STATE_W(STATE_W), .CODE_START(CODE_START), .CODE_HEAD(CODE_HEAD),
    .CODE_LOW(CODE_LOW), .CODE_HIGH(CODE_HIGH)
  ) u_encode (
    .nxt (nxt),
    .code(st_d)
  );

  seq_frame_out u_out (
    .in_high(role.high),
    .din    (din),
    .hit    (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) st_q <= CODE_START;
    else     st_q <= st_d;
  end

endmodule

// File: rtl/seq_frame_det_chk.sv
module seq_frame_det_chk #(
  parameter int                 STATE_W    = 2,
  parameter logic [STATE_W-1:0] CODE_START = 2'd0,
  parameter logic [STATE_W-1:0] CODE_HEAD  = 2'd1
) (
  input logic               clk,
  input logic               rst,
  input logic               din,
  input logic               hit,
  input logic [STATE_W-1:0] st
);

  // Independent frame position: 0 opening, 1 middle, 2 closing.
  logic [1:0] pos;
  always_ff @(posedge clk) begin
    if (rst)           pos <= 2'd0;
    else if (pos == 2) pos <= 2'd0;
    else               pos <= pos + 2'd1;
  end

  AST_RESET_START: assert property (@(posedge clk) rst |=> st == CODE_START); // R1
  AST_HIT_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (pos == 2 && $past(din) && !din) |-> hit); // R2
  AST_NO_HIT_OFF_MATCH: assert property (@(posedge clk) disable iff (rst)
    (pos == 2 && !(($past(din)) && !din)) |-> !hit); // R2
  AST_HEAD_MERGED: assert property (@(posedge clk) disable iff (rst)
    (pos == 1) |-> st == CODE_HEAD); // R3
  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (rst)
    (pos == 0) |-> st == CODE_START); // R4
  AST_QUIET_EARLY: assert property (@(posedge clk) disable iff (rst)
    (pos != 2) |-> !hit); // R5

endmodule

bind seq_frame_det seq_frame_det_chk #(
  .STATE_W(STATE_W), .CODE_START(CODE_START), .CODE_HEAD(CODE_HEAD)
) u_chk (
  .clk(clk), .rst(rst), .din(din), .hit(hit), .st(st_q)
);

// File: tb/seq_frame_det_test.sv
`timescale 1ns/1ps
module seq_frame_det_test;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit;
  logic hit_alt;

  int checks = 0;
  int errors = 0;
  item_t q[$];

  // Reference model state
  int   m_pos  = 0;
  logic m_prev = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  seq_frame_det uut (.clk(clk), .rst(rst), .din(din), .hit(hit));

  seq_frame_det #(
    .STATE_W(4), .CODE_START(4'b0001), .CODE_HEAD(4'b0010),
    .CODE_LOW(4'b0100), .CODE_HIGH(4'b1000)
  ) uut_alt (.clk(clk), .rst(rst), .din(din), .hit(hit_alt));

  // Driver: one bit per cycle, expected result pushed in the same cycle.
  task automatic send(input logic b, input logic r, input string tag);
    item_t it;
    @(negedge clk);
    din = b;
    rst = r;
    it.exp = (m_pos == 2) && m_prev && !b;
    if (tag != "")       it.tag = tag;
    else if (r)          it.tag = "R1";
    else if (m_pos == 2) it.tag = "R2";
    else                 it.tag = "R5";
    q.push_back(it);
    m_prev = b;
    if (r)               m_pos = 0;
    else if (m_pos == 2) m_pos = 0;
    else                 m_pos = m_pos + 1;
  endtask

  task automatic frame(input logic [2:0] f, input string tag);
    send(f[2], 1'b0, "");
    send(f[1], 1'b0, "");
    send(f[0], 1'b0, tag);
  endtask

  // Monitor: samples 5 ns after the falling edge, before the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (hit !== it.exp) begin
          errors++;
          $display("FAIL %s: hit=%b expected=%b at %0t", it.tag, hit, it.exp, $time);
        end
        checks++;
        if (hit_alt !== it.exp) begin
          errors++;
          $display("FAIL R7: one-hot hit=%b expected=%b at %0t", hit_alt, it.exp, $time);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(posedge clk);
    @(posedge clk);
    // R1: reset cycles hold the start state, hit stays low
    repeat (3) send(1'b1, 1'b1, "R1");
    // R3: opening bit ignored
    frame(3'b010, "R3");
    frame(3'b110, "R3");
    frame(3'b000, "R3");
    frame(3'b100, "R3");
    frame(3'b011, "R3");
    frame(3'b111, "R3");
    // R4: patterns straddling frame boundaries must not fire
    frame(3'b001, "R4");
    frame(3'b001, "R4");
    frame(3'b011, "R4");
    frame(3'b001, "R4");
    // R1: reset in mid-frame, then the next bit opens a new frame
    send(1'b0, 1'b0, "");
    send(1'b1, 1'b0, "");
    send(1'b0, 1'b1, "R1");
    send(1'b1, 1'b0, "R1");
    send(1'b0, 1'b0, "R1");
    send(1'b0, 1'b0, "R1");
    // R6: hit follows din within the closing cycle
    send(1'b1, 1'b0, "");
    send(1'b1, 1'b0, "");
    send(1'b0, 1'b0, "R6");
    // Random stream
    for (int i = 0; i < 3000; i++) begin
      send(1'($urandom_range(0, 1)), 1'b0, "");
    end
    @(negedge clk);
    #10;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule